// File: doc/BRIEF.md
# Dual-Mode Host Register Port for a Tone Transceiver

This block is the host-side register port of a tone transceiver. A small microcontroller reaches four registers through a 4-bit data bus, one register-select line and three control pins. The `intel_mode` input is held static. When it is low, the pins follow a direction-plus-data-strobe protocol (Motorola style). When it is high, the same two pins act as separate active-low write and read strobes (Intel style). The bidirectional bus is modelled as separate `d_in`, `d_out` and `d_oe` signals, so the pad ring builds the tri-state driver.

Host pins are brought into the `clk` domain through a parameterised synchroniser and then decoded into a read-active and a write-active condition. The access state machine has three states: `ST_IDLE`, `ST_READ` and `ST_WRITE`. It makes these transitions:
- idle-to-read: a read strobe is active. Read has priority when both are active.
- idle-to-write: a write strobe is active.
- read-to-idle: the read strobe ends. This emits a read-done pulse.
- write-to-idle: the write strobe ends. This emits a commit pulse carrying the data and register select seen in the last active cycle.

The register file sits behind the state machine. It holds the transmit code, the control nibble, the latest received code, the received and transmitted flags, and a registered active-low interrupt output.

Top module: `tone_host_port`

## Requirements
- R1: After reset, `irq_n` is 1, `d_oe` is 0, `tx_code` and `ctrl_q` are 0, and `tx_load` is 0.
- R2: With `intel_mode`=0, `d_oe` becomes 1 while `cs_n`=0, `ds_rd`=1 and `rw_wr`=1. It is 0 whenever `cs_n`=1 or `ds_rd`=0.
- R3: With `intel_mode`=1, `d_oe` becomes 1 while `cs_n`=0 and `ds_rd`=0. It is 0 whenever `cs_n`=1 or `ds_rd`=1.
- R4: A write is taken on the trailing edge of the strobe, using the `d_in` and `rs` values of its last active cycle. A write is `ds_rd` falling with `rw_wr`=0 in Motorola mode, or `rw_wr` rising in Intel mode. With `rs`=0 the value goes to `tx_code` and `tx_load` pulses for exactly one cycle. With `rs`=1 the value goes to `ctrl_q`.
- R5: A read with `rs`=0 returns the code from the most recent `rx_valid` pulse.
- R6: A read with `rs`=1 returns status as follows: bit 2 is the received flag, bit 1 is the transmitted flag, bit 0 is 1 while `irq_n` is low, and bit 3 is 0.
- R7: `rx_valid` sets the received flag and `tx_done` sets the transmitted flag. When `ctrl_q` bit 1 is 1, `irq_n` goes low two cycles after either event. When that bit is 0, `irq_n` stays 1.
- R8: The end of a status read clears both flags, and `irq_n` returns to 1. An event that arrives in the clearing cycle keeps its flag set.
- R9: Strobe activity while `cs_n`=1 has no effect: `ctrl_q` and `tx_code` keep their values and `tx_load` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| intel_mode | input | 1 | 0: direction + data strobe; 1: separate write/read strobes |
| cs_n | input | 1 | Chip select, active low, already address-qualified |
| rs | input | 1 | Register select |
| rw_wr | input | 1 | Read/write direction (mode 0) or write strobe, active low (mode 1) |
| ds_rd | input | 1 | Data strobe, active high (mode 0) or read strobe, active low (mode 1) |
| d_in | input | DW | Data from host bus |
| d_out | output | DW | Data to host bus |
| d_oe | output | 1 | Bus driver enable |
| irq_n | output | 1 | Interrupt request, active low |
| rx_valid | input | 1 | One-cycle pulse: a received code is valid |
| rx_code | input | DW | Received tone code |
| tx_done | input | 1 | One-cycle pulse: a tone burst has been sent |
| tx_code | output | DW | Code to transmit |
| tx_load | output | 1 | One-cycle pulse when `tx_code` is written |
| ctrl_q | output | DW | Control nibble |

## Verification
The bench builds the block with `DW`=4 and `SYNC_STAGES`=3, one stage deeper than the default. This lengthens the path from pin change to `d_oe` and to commit. It also makes every check depend on a strobe being held longer than that pipeline, not on a particular latency. Both bus modes are run in the same build by changing `intel_mode` while the bus is idle. This covers both the commit on the trailing edge and the tri-state conditions under each pin meaning.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } acc_state_t;

    localparam int STS_IRQ_BIT  = 0;
    localparam int STS_TX_BIT   = 1;
    localparam int STS_RX_BIT   = 2;
    localparam int CTRL_IRQ_BIT = 1;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_strobe_decode.sv
module hbi_strobe_decode (
    input  logic intel_mode,
    input  logic cs_n,
    input  logic rw_wr,
    input  logic ds_rd,
    output logic rd_act,
    output logic wr_act
);
    always_comb begin
        if (intel_mode) begin
            rd_act = !cs_n && !ds_rd;
            wr_act = !cs_n && !rw_wr && ds_rd;
        end else begin
            rd_act = !cs_n && ds_rd && rw_wr;
            wr_act = !cs_n && ds_rd && !rw_wr;
        end
    end
endmodule

// File: rtl/hbi_access_fsm.sv
module hbi_access_fsm
    import hbi_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          wr_act,
    input  logic          rs,
    input  logic [DW-1:0] din,
    output acc_state_t    state,
    output logic          rd_sel,
    output logic          rd_done,
    output logic          wr_commit,
    output logic          wr_sel,
    output logic [DW-1:0] wr_data
);
    acc_state_t    state_q, state_d;
    logic [DW-1:0] hold_data;
    logic          hold_rs;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_act)      state_d = ST_READ;
                else if (wr_act) state_d = ST_WRITE;
            end
            ST_READ:  if (!rd_act) state_d = ST_IDLE;
            ST_WRITE: if (!wr_act) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sel    <= 1'b0;
            rd_done   <= 1'b0;
            wr_commit <= 1'b0;
            wr_sel    <= 1'b0;
            wr_data   <= '0;
            hold_data <= '0;
            hold_rs   <= 1'b0;
        end else begin
            rd_done   <= 1'b0;
            wr_commit <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (rd_act) rd_sel <= rs;
                    else if (wr_act) begin
                        hold_data <= din;
                        hold_rs   <= rs;
                    end
                end
                ST_READ: if (!rd_act) rd_done <= 1'b1;
                ST_WRITE: begin
                    if (wr_act) begin
                        hold_data <= din;
                        hold_rs   <= rs;
                    end else begin
                        wr_commit <= 1'b1;
                        wr_data   <= hold_data;
                        wr_sel    <= hold_rs;
                    end
                end
                default: ;
            endcase
        end
    end

    assign state = state_q;

    // R4
    commit_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(state_q) == ST_WRITE);
    // R2
    no_read_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> (state_q != ST_WRITE));
    // R4
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
endmodule

// File: rtl/hbi_regfile.sv
module hbi_regfile
    import hbi_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit,
    input  logic          wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_done,
    input  logic          rd_sel,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_code,
    input  logic          tx_done,
    output logic [DW-1:0] rd_data,
    output logic          irq_n,
    output logic [DW-1:0] tx_code,
    output logic          tx_load,
    output logic [DW-1:0] ctrl_q
);
    logic [DW-1:0] rx_code_q;
    logic          rx_flag, tx_flag;
    logic          status_clear;
    logic [DW-1:0] status_word;

    assign status_clear = rd_done && rd_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_code <= '0;
            tx_load <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            tx_load <= 1'b0;
            if (wr_commit) begin
                if (wr_sel) ctrl_q <= wr_data;
                else begin
                    tx_code <= wr_data;
                    tx_load <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_code_q <= '0;
            rx_flag   <= 1'b0;
            tx_flag   <= 1'b0;
            irq_n     <= 1'b1;
        end else begin
            if (rx_valid) rx_code_q <= rx_code;
            if (rx_valid)          rx_flag <= 1'b1;
            else if (status_clear) rx_flag <= 1'b0;
            if (tx_done)           tx_flag <= 1'b1;
            else if (status_clear) tx_flag <= 1'b0;
            irq_n <= !(ctrl_q[CTRL_IRQ_BIT] && (rx_flag || tx_flag));
        end
    end

    always_comb begin
        status_word              = '0;
        status_word[STS_IRQ_BIT] = !irq_n;
        status_word[STS_TX_BIT]  = tx_flag;
        status_word[STS_RX_BIT]  = rx_flag;
        rd_data = rd_sel ? status_word : rx_code_q;
    end

    // R7
    rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_flag);
    // R8
    flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clear && !rx_valid && !tx_done) |=> (!rx_flag && !tx_flag));
    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clear && !rx_valid && !tx_done) ##1 (!rx_valid && !tx_done) |=> irq_n);
    // R4
    tx_load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load);
endmodule

// File: rtl/tone_host_port.sv
module tone_host_port
    import hbi_pkg::*;
#(
    parameter int DW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          intel_mode,
    input  logic          cs_n,
    input  logic          rs,
    input  logic          rw_wr,
    input  logic          ds_rd,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out,
    output logic          d_oe,
    output logic          irq_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_code,
    input  logic          tx_done,
    output logic [DW-1:0] tx_code,
    output logic          tx_load,
    output logic [DW-1:0] ctrl_q
);
    localparam int PW = DW + 4;
    localparam logic [PW-1:0] PIN_RST = {1'b1, 1'b0, 1'b1, 1'b0, {DW{1'b0}}};

    logic [PW-1:0] pins_raw, pins_s;
    logic          cs_n_s, rs_s, rw_wr_s, ds_rd_s;
    logic [DW-1:0] din_s;
    logic          rd_act, wr_act;
    acc_state_t    state;
    logic          rd_sel, rd_done, wr_commit, wr_sel;
    logic [DW-1:0] wr_data, rd_data;

    assign pins_raw = {cs_n, rs, rw_wr, ds_rd, d_in};

    hbi_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s));

    assign {cs_n_s, rs_s, rw_wr_s, ds_rd_s, din_s} = pins_s;

    hbi_strobe_decode u_dec (
        .intel_mode(intel_mode), .cs_n(cs_n_s), .rw_wr(rw_wr_s), .ds_rd(ds_rd_s),
        .rd_act(rd_act), .wr_act(wr_act));

    hbi_access_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .wr_act(wr_act),
        .rs(rs_s), .din(din_s), .state(state), .rd_sel(rd_sel),
        .rd_done(rd_done), .wr_commit(wr_commit), .wr_sel(wr_sel), .wr_data(wr_data));

    hbi_regfile #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_done(rd_done), .rd_sel(rd_sel),
        .rx_valid(rx_valid), .rx_code(rx_code), .tx_done(tx_done),
        .rd_data(rd_data), .irq_n(irq_n), .tx_code(tx_code),
        .tx_load(tx_load), .ctrl_q(ctrl_q));

    assign d_oe  = (state == ST_READ);
    assign d_out = rd_data;

    // R2
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> $past(rd_act));
    // R9
    no_commit_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(cs_n_s, 2) == 1'b0);
endmodule

// File: tb/test_tone_host_port.sv
module test_tone_host_port;
    localparam int DW = 4;
    localparam int SYNC = 3;
    localparam int SETTLE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic intel_mode = 1'b0;
    logic cs_n = 1'b1, rs = 1'b0, rw_wr = 1'b1, ds_rd = 1'b0;
    logic [DW-1:0] d_in = '0, rx_code = '0;
    logic rx_valid = 1'b0, tx_done = 1'b0;
    logic [DW-1:0] d_out, tx_code, ctrl_q;
    logic d_oe, irq_n, tx_load;

    int n_tests = 0, n_fail = 0, load_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tone_host_port #(.DW(DW), .SYNC_STAGES(SYNC)) i_tone_host_port (
        .clk(clk), .rst_n(rst_n), .intel_mode(intel_mode), .cs_n(cs_n), .rs(rs),
        .rw_wr(rw_wr), .ds_rd(ds_rd), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .irq_n(irq_n), .rx_valid(rx_valid), .rx_code(rx_code), .tx_done(tx_done),
        .tx_code(tx_code), .tx_load(tx_load), .ctrl_q(ctrl_q));

    always @(posedge clk) if (tx_load) load_cnt++;

    // scoreboard for bus read data
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic [DW-1:0] obs_val;
    event          obs_ev;

    initial forever begin
        @(obs_ev);
        begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_tests++;
            if (obs_val !== e) begin
                n_fail++;
                $display("FAIL %s bus data: got %h expected %h", t, obs_val, e);
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", t, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_pins();
        cs_n = 1'b1;
        rw_wr = 1'b1;
        ds_rd = intel_mode ? 1'b1 : 1'b0;
    endtask

    task automatic host_write(input logic sel, input logic [DW-1:0] v, input logic chip);
        rs = sel; d_in = v; cs_n = !chip;
        if (intel_mode) rw_wr = 1'b0;
        else begin rw_wr = 1'b0; ds_rd = 1'b1; end
        settle();
        idle_pins();
        settle();
    endtask

    task automatic host_read(input logic sel, input logic [DW-1:0] e, input string t);
        rs = sel; cs_n = 1'b0;
        if (intel_mode) ds_rd = 1'b0;
        else begin rw_wr = 1'b1; ds_rd = 1'b1; end
        settle();
        check({t, " oe during read"}, d_oe, 1);
        exp_q.push_back(e);
        tag_q.push_back(t);
        obs_val = d_out;
        -> obs_ev;
        idle_pins();
        settle();
        check({t, " oe released"}, d_oe, 0);
    endtask

    task automatic pulse_rx(input logic [DW-1:0] c);
        @(negedge clk); rx_code = c; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_tx();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        settle();
        // R1 reset state
        check("R1 irq_n", irq_n, 1);
        check("R1 d_oe", d_oe, 0);
        check("R1 tx_code", tx_code, 0);
        check("R1 ctrl_q", ctrl_q, 0);
        check("R1 tx_load", load_cnt, 0);

        // Motorola mode
        host_write(1'b1, 4'b0010, 1'b1);
        check("R4 ctrl write moto", ctrl_q, 4'b0010);
        host_write(1'b0, 4'h9, 1'b1);
        check("R4 tx write moto", tx_code, 4'h9);
        check("R4 tx_load once", load_cnt, 1);

        cs_n = 1'b1; ds_rd = 1'b1; rw_wr = 1'b1; settle();
        check("R2 hiz cs high", d_oe, 0);
        cs_n = 1'b0; ds_rd = 1'b0; settle();
        check("R2 hiz ds low", d_oe, 0);
        idle_pins(); settle();

        pulse_rx(4'h5);
        repeat (2) @(negedge clk);
        check("R7 irq low after rx", irq_n, 0);
        host_read(1'b0, 4'h5, "R5 rx code moto");
        host_read(1'b1, 4'b0101, "R6 status rx+irq");
        check("R8 irq released", irq_n, 1);
        host_read(1'b1, 4'b0000, "R8 status cleared");

        host_write(1'b1, 4'hF, 1'b0);
        check("R9 ctrl unchanged", ctrl_q, 4'b0010);
        check("R9 no tx_load", load_cnt, 1);
        host_write(1'b0, 4'h3, 1'b0);
        check("R9 tx_code unchanged", tx_code, 4'h9);

        // Intel mode
        intel_mode = 1'b1; idle_pins(); settle();
        host_write(1'b0, 4'hC, 1'b1);
        check("R4 tx write intel", tx_code, 4'hC);
        check("R4 tx_load intel", load_cnt, 2);
        pulse_tx();
        repeat (2) @(negedge clk);
        check("R7 irq low after tx", irq_n, 0);
        host_read(1'b1, 4'b0011, "R6 status tx+irq");
        check("R8 irq released intel", irq_n, 1);

        host_write(1'b1, 4'b0000, 1'b1);
        check("R4 ctrl write intel", ctrl_q, 0);
        pulse_rx(4'hA);
        settle();
        check("R7 irq masked", irq_n, 1);
        host_read(1'b1, 4'b0100, "R6 status rx only");
        host_read(1'b0, 4'hA, "R5 rx code intel");

        cs_n = 1'b0; ds_rd = 1'b1; settle();
        check("R3 hiz rd high", d_oe, 0);
        cs_n = 1'b1; ds_rd = 1'b0; settle();
        check("R3 hiz cs high", d_oe, 0);
        cs_n = 1'b0; settle();
        check("R3 oe rd low", d_oe, 1);
        idle_pins(); settle();
        check("R3 oe released", d_oe, 0);

        settle();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule